// File: doc/BRIEF.md
# Self-Paced Burst Read Streamer with CRC-32 Trailer

This block runs one burst read for a debug port that is reached over a JTAG data register. A command decoder latches a start address, a word count and a word size, then pulses a start strobe. The engine then reads words from a system bus through a request/acknowledge master port. It shifts each word out on TDO during Shift-DR cycles. Each word is preceded by a ready marker: the block sends zeros until a word is in hand, then a single one, then the word itself, least significant bit first.

After the last word the block appends a 32-bit checksum over every data bit it sent. The host recomputes the same checksum and compares. A bus error sets a sticky flag and keeps the failing address until software clears it. The engine prefetches one word ahead, so a fast bus adds no extra zero markers between words. An Update-DR ends the burst at once, whatever state it is in.

Top module: `burst_read_streamer`

## Requirements
- R1: After reset tdo is 0, busReq is 0, errFlag is 0 and errAddr is 0.
- R2: During Shift-DR the block sends a 0 status bit in every cycle in which the next word has not arrived yet. Once it has arrived, the block sends exactly one 1.
- R3: After the 1 marker, the word follows least significant bit first. Its width comes from sizeSel: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. The word is taken from busRdata right-justified, and the upper bits are ignored.
- R4: The first fetch uses startAddr. Each later fetch adds the word size in bytes (1, 2 or 4). busSize reports the latched sizeSel.
- R5: busReq stays high with a stable busAddr until busAck or busErr is seen in a cycle where busReq is high. It drops on the following edge.
- R6: After the last word the block sends 32 checksum bits, least significant bit first, and then only zeros. The checksum starts at 0xFFFFFFFF. For each data bit in send order, the register shifts right by one. It is XORed with 0xEDB88320 when the data bit XOR the register's old bit 0 is 1.
- R7: At most one word is held ahead of the shifter. The next fetch is issued while the current word shifts. With a bus that answers in the cycle after the request, no word after the first is preceded by any 0 status bit.
- R8: With a nonzero wordCount, busReq is high right after the clock edge that takes startValid. The first fetch therefore starts before any shifting.
- R9: A busErr response sets errFlag, stores the fetch address in errAddr and replaces that word's data with zeros. While errFlag is set, later errors leave errAddr unchanged.
- R10: An errClr pulse clears errFlag and errAddr to 0.
- R11: An updateDr pulse during a burst ends it. busReq is low after that edge, tdo stays 0, and a busAck arriving afterwards has no effect.
- R12: A start with wordCount 0 is ignored: busReq stays low and tdo stays 0.
- R13: In a cycle with shiftDr low the stream does not advance, and tdo holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, shared with the bus port |
| rstN | input | 1 | Active-low reset |
| startValid | input | 1 | Start pulse from the command decoder |
| startAddr | input | ADDR_W | First bus address |
| wordCount | input | CNT_W | Number of words in the burst |
| sizeSel | input | 2 | Word size: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| shiftDr | input | 1 | Shift-DR strobe: one bit per cycle |
| updateDr | input | 1 | Update-DR strobe: ends the burst |
| tdo | output | 1 | Serial output |
| busReq | output | 1 | Bus read request |
| busAddr | output | ADDR_W | Bus read address |
| busSize | output | 2 | Latched word size |
| busAck | input | 1 | Bus read done |
| busErr | input | 1 | Bus read failed |
| busRdata | input | 32 | Bus read data, right-justified |
| errFlag | output | 1 | Sticky bus error flag |
| errAddr | output | ADDR_W | Address of the first failed fetch |
| errClr | input | 1 | Write-one-to-clear for the error record |

## Verification
The bench gives the bus responder random latencies and checks how many zero markers come before each word. An engine that fails to prefetch passes at slow latencies but shows extra zeros when the bus answers at once. Checksums are recomputed bit by bit in the bench. A wrong polynomial, a wrong seed or the wrong bit order then changes the trailer even when every word is right. Directed cases cover:
- an Update-DR with a fetch still outstanding, followed by a stray acknowledge;
- a second bus error while the flag is already set, which would overwrite the stored address if the record were not sticky;
- pauses in Shift-DR that a free-running shifter would skip over;
- a zero word count, which a careless engine would turn into a wrapped counter and an endless fetch.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int MAX_W = 32;
  localparam int CRC_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_DATA, ST_CRC, ST_DONE
  } brsState_e;

  typedef struct packed {
    logic start;
    logic fetchDone;
    logic loadWord;
    logic shiftWord;
    logic shiftCrc;
  } brsStrobe_t;

  function automatic logic [5:0] sizeBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] sizeBytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crc,
                                               input logic din,
                                               input logic [CRC_W-1:0] poly);
    return (crc >> 1) ^ ((din ^ crc[0]) ? poly : '0);
  endfunction
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [1:0]       sizeSel,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             busAck,
  input  logic             busErr,
  input  logic             shBit,
  input  logic             crcBit,
  output logic             tdo,
  output logic             busReq,
  output logic [1:0]       sizeReg,
  output brsStrobe_t       strobe
);
  brsState_e        state;
  logic [CNT_W-1:0] wordsToSend;
  logic [CNT_W-1:0] fetchesLeft;
  logic             bufFull;
  logic             reqReg;
  logic [5:0]       bitCnt;
  logic [4:0]       crcCnt;
  logic             active, abort, go, lastBit;

  assign active  = (state != ST_IDLE);
  assign abort   = updateDr && active && !startValid;
  assign go      = active && !startValid && !abort;
  assign lastBit = (bitCnt == sizeBits(sizeReg) - 6'd1);
  assign busReq  = reqReg;

  always_comb begin
    strobe.start     = startValid;
    strobe.fetchDone = go && reqReg && (busAck || busErr);
    strobe.loadWord  = go && (state == ST_STAT) && shiftDr && bufFull;
    strobe.shiftWord = go && (state == ST_DATA) && shiftDr;
    strobe.shiftCrc  = go && (state == ST_CRC) && shiftDr;
  end

  always_comb begin
    case (state)
      ST_STAT: tdo = bufFull;
      ST_DATA: tdo = shBit;
      ST_CRC:  tdo = crcBit;
      default: tdo = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wordsToSend <= '0;
      fetchesLeft <= '0;
      bufFull     <= 1'b0;
      reqReg      <= 1'b0;
      bitCnt      <= '0;
      crcCnt      <= '0;
      sizeReg     <= '0;
    end else if (startValid) begin
      state       <= (wordCount != '0) ? ST_STAT : ST_IDLE;
      wordsToSend <= wordCount;
      fetchesLeft <= wordCount;
      bufFull     <= 1'b0;
      reqReg      <= (wordCount != '0);
      bitCnt      <= '0;
      crcCnt      <= '0;
      sizeReg     <= sizeSel;
    end else if (abort) begin
      state   <= ST_IDLE;
      reqReg  <= 1'b0;
      bufFull <= 1'b0;
    end else if (active) begin
      // fetch side: one word may wait in the buffer
      if (strobe.fetchDone) begin
        reqReg      <= 1'b0;
        bufFull     <= 1'b1;
        fetchesLeft <= fetchesLeft - 1'b1;
      end else if (!reqReg && !bufFull && fetchesLeft != '0) begin
        reqReg <= 1'b1;
      end
      // shift side
      if (strobe.loadWord) begin
        bufFull <= 1'b0;
        bitCnt  <= '0;
        state   <= ST_DATA;
      end else if (strobe.shiftWord) begin
        bitCnt <= bitCnt + 6'd1;
        if (lastBit) begin
          wordsToSend <= wordsToSend - 1'b1;
          state       <= (wordsToSend == 1) ? ST_CRC : ST_STAT;
          crcCnt      <= '0;
        end
      end else if (strobe.shiftCrc) begin
        crcCnt <= crcCnt + 5'd1;
        if (crcCnt == 5'd31) state <= ST_DONE;
      end
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqReg && !busAck && !busErr && !updateDr && !startValid |=> reqReg);
  assert_single_buffer_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(bufFull && reqReg));
  assert_abort_drops_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    updateDr && !startValid |=> !busReq);
  assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    startValid && wordCount == '0 |=> !busReq);
  assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DATA |-> bitCnt < sizeBits(sizeReg));
endmodule

// File: rtl/brs_datapath.sv
module brs_datapath
  import brs_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rstN,
  input  brsStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        sizeReg,
  input  logic              reqPending,
  input  logic              busErr,
  input  logic [MAX_W-1:0]  busRdata,
  input  logic              errClr,
  output logic [ADDR_W-1:0] busAddr,
  output logic              shBit,
  output logic              crcBit,
  output logic              errFlag,
  output logic [ADDR_W-1:0] errAddr
);
  logic [ADDR_W-1:0] addrReg;
  logic [MAX_W-1:0]  bufData;
  logic [MAX_W-1:0]  shReg;
  logic [CRC_W-1:0]  crcReg;
  logic              errHit;

  assign busAddr = addrReg;
  assign shBit   = shReg[0];
  assign crcBit  = crcReg[0];
  assign errHit  = strobe.fetchDone && busErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      bufData <= '0;
      shReg   <= '0;
      crcReg  <= '1;
    end else begin
      if (strobe.start) begin
        addrReg <= startAddr;
        crcReg  <= '1;
      end else begin
        if (strobe.fetchDone) begin
          addrReg <= addrReg + ADDR_W'(sizeBytes(sizeReg));
          bufData <= busErr ? '0 : busRdata;
        end
        if (strobe.loadWord) begin
          shReg <= bufData;
        end else if (strobe.shiftWord) begin
          shReg  <= shReg >> 1;
          crcReg <= crcStep(crcReg, shReg[0], CRC_POLY);
        end else if (strobe.shiftCrc) begin
          crcReg <= crcReg >> 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errAddr <= '0;
    end else if (errHit && !errFlag) begin
      errFlag <= 1'b1;
      errAddr <= addrReg;
    end else if (errClr) begin
      errFlag <= 1'b0;
      errAddr <= '0;
    end
  end

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqPending && !strobe.fetchDone && !strobe.start |=> $stable(busAddr));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClr |=> errFlag && $stable(errAddr));
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    errClr && !errHit |=> !errFlag && errAddr == '0);
endmodule

// File: rtl/burst_read_streamer.sv
module burst_read_streamer
  import brs_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               CNT_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [1:0]        sizeSel,
  input  logic              shiftDr,
  input  logic              updateDr,
  output logic              tdo,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [MAX_W-1:0]  busRdata,
  output logic              errFlag,
  output logic [ADDR_W-1:0] errAddr,
  input  logic              errClr
);
  brsStrobe_t strobe;
  logic       shBit, crcBit;
  logic [1:0] sizeReg;

  assign busSize = sizeReg;

  brs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .wordCount(wordCount),
    .sizeSel(sizeSel), .shiftDr(shiftDr), .updateDr(updateDr),
    .busAck(busAck), .busErr(busErr), .shBit(shBit), .crcBit(crcBit),
    .tdo(tdo), .busReq(busReq), .sizeReg(sizeReg), .strobe(strobe)
  );

  brs_datapath #(.ADDR_W(ADDR_W), .CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .sizeReg(sizeReg), .reqPending(busReq), .busErr(busErr),
    .busRdata(busRdata), .errClr(errClr), .busAddr(busAddr),
    .shBit(shBit), .crcBit(crcBit), .errFlag(errFlag), .errAddr(errAddr)
  );
endmodule

// File: tb/burst_read_streamer_bench.sv
`timescale 1ns/1ps
module burst_read_streamer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startAddr = '0;
  logic [15:0] wordCount = '0;
  logic [1:0]  sizeSel = '0;
  logic        shiftDr = 1'b0;
  logic        updateDr = 1'b0;
  logic        tdo, busReq, errFlag;
  logic [31:0] busAddr, errAddr;
  logic [1:0]  busSize;
  logic        respAck = 1'b0, respErr = 1'b0, strayAck = 1'b0;
  logic        busAck, busErr;
  logic [31:0] busRdata = '0;
  logic        errClr = 1'b0;

  int          applied = 0;
  int          failed = 0;
  int          cyc = 0;
  int          maxLat = 0;
  bit          errOn = 0;
  logic [31:0] errTarget = '0;
  logic [31:0] logArr [64];
  int          logN = 0;

  assign busAck = respAck | strayAck;
  assign busErr = respErr;

  always #4 clk = ~clk;

  burst_read_streamer u_burst_read_streamer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .wordCount(wordCount), .sizeSel(sizeSel), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdo(tdo), .busReq(busReq), .busAddr(busAddr),
    .busSize(busSize), .busAck(busAck), .busErr(busErr), .busRdata(busRdata),
    .errFlag(errFlag), .errAddr(errAddr), .errClr(errClr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A55A3C;
  endfunction

  function automatic int bitsOf(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] crcBitModel(input logic [31:0] c, input logic d);
    return (c >> 1) ^ ((d ^ c[0]) ? 32'hEDB88320 : 32'h0);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    applied++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder: random latency, one response per request
  int  waitCnt = 0;
  bit  served = 0;
  bit  armed = 0;
  always @(negedge clk) begin
    respAck = 1'b0;
    respErr = 1'b0;
    if (!busReq) begin
      armed = 0; served = 0;
    end else if (!served) begin
      if (!armed) begin
        waitCnt = (maxLat > 0) ? $urandom_range(maxLat, 0) : 0;
        armed = 1;
      end
      if (waitCnt == 0) begin
        busRdata = memWord(busAddr);
        if (errOn && busAddr == errTarget) respErr = 1'b1;
        else respAck = 1'b1;
        if (logN < 64) logArr[logN] = busAddr;
        logN++;
        served = 1;
      end else waitCnt--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failed++;
      applied++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  task automatic shiftBit(output logic b);
    @(negedge clk);
    shiftDr = 1'b1;
    #1 b = tdo;
  endtask

  task automatic endShift();
    @(negedge clk);
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge clk);
    updateDr = 1'b0;
  endtask

  task automatic runBurst(input logic [1:0] sz, input int cnt, input logic [31:0] addr,
                          input int lat, input bit chkFast, input bit holdMid);
    logic [31:0] crcExp, got, exp, a;
    logic b;
    int   zeros, w;
    w = bitsOf(sz);
    maxLat = lat;
    logN = 0;
    crcExp = 32'hFFFFFFFF;
    @(negedge clk);
    startValid = 1'b1; startAddr = addr; wordCount = 16'(cnt); sizeSel = sz;
    @(negedge clk);
    startValid = 1'b0;
    check(busReq == 1'b1, "R8 first request right after start", {31'd0, busReq}, 32'd1);
    check(busSize == sz, "R4 busSize", {30'd0, busSize}, {30'd0, sz});
    for (int i = 0; i < cnt; i++) begin
      a = addr + 32'(i * (w / 8));
      zeros = 0;
      shiftBit(b);
      while (!b && zeros < 300) begin
        zeros++;
        shiftBit(b);
      end
      check(zeros < 300, "R2 ready marker arrives", 32'(zeros), 32'd0);
      if (chkFast && i > 0)
        check(zeros == 0, "R7 prefetch leaves no status gap", 32'(zeros), 32'd0);
      exp = (errOn && a == errTarget) ? 32'h0 : memWord(a);
      if (w < 32) exp = exp & ((32'd1 << w) - 32'd1);
      got = '0;
      for (int k = 0; k < w; k++) begin
        if (holdMid && i == 0 && k == 3) begin
          for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            shiftDr = 1'b0;
            #1 check(tdo == exp[k], "R13 stream holds without shift", {31'd0, tdo},
                     {31'd0, exp[k]});
          end
        end
        shiftBit(b);
        got[k] = b;
        crcExp = crcBitModel(crcExp, exp[k]);
      end
      check(got == exp, "R3 word data LSB first", got, exp);
    end
    got = '0;
    for (int k = 0; k < 32; k++) begin
      shiftBit(b);
      got[k] = b;
    end
    check(got == crcExp, "R6 CRC trailer", got, crcExp);
    shiftBit(b);
    check(b == 1'b0, "R6 zeros after trailer", {31'd0, b}, 32'd0);
    endShift();
    check(logN == cnt, "R4 fetch count", 32'(logN), 32'(cnt));
    for (int i = 0; i < cnt && i < 64; i++)
      check(logArr[i] == addr + 32'(i * (w / 8)), "R4 address step",
            logArr[i], addr + 32'(i * (w / 8)));
  endtask

  initial begin
    logic b;
    logic [31:0] firstErr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(tdo == 1'b0, "R1 reset tdo", {31'd0, tdo}, 32'd0);
    check(busReq == 1'b0, "R1 reset busReq", {31'd0, busReq}, 32'd0);
    check(errFlag == 1'b0 && errAddr == 32'd0, "R1 reset error record", errAddr, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed: each size, fast bus
    runBurst(2'd2, 4, 32'h0000_1000, 0, 1, 0);
    runBurst(2'd0, 5, 32'h0000_2003, 0, 1, 0);
    runBurst(2'd1, 3, 32'h0000_3002, 0, 1, 0);
    runBurst(2'd3, 2, 32'h0000_4000, 0, 1, 0);
    // slow bus: zero markers expected, data must still be right (R2)
    runBurst(2'd2, 3, 32'h0000_5000, 12, 0, 0);
    // pause in the middle of a word (R13)
    runBurst(2'd0, 2, 32'h0000_6000, 0, 1, 1);

    // random mix
    for (int n = 0; n < 12; n++) begin
      logic [1:0] s;
      int l;
      s = 2'($urandom_range(2, 0));
      l = $urandom_range(4, 0);
      runBurst(s, $urandom_range(6, 1), $urandom & 32'hFFFF_FFFC, l, (l == 0), 0);
    end

    // bus error records first address and stays sticky (R9)
    errOn = 1; errTarget = 32'h0000_7008;
    runBurst(2'd2, 4, 32'h0000_7000, 1, 0, 0);
    check(errFlag == 1'b1, "R9 flag set on bus error", {31'd0, errFlag}, 32'd1);
    check(errAddr == 32'h0000_7008, "R9 failing address", errAddr, 32'h0000_7008);
    firstErr = errAddr;
    errTarget = 32'h0000_8004;
    runBurst(2'd2, 3, 32'h0000_8000, 0, 1, 0);
    check(errAddr == firstErr, "R9 later error keeps first address", errAddr, firstErr);
    errOn = 0;
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    #1;
    check(errFlag == 1'b0, "R10 clear flag", {31'd0, errFlag}, 32'd0);
    check(errAddr == 32'd0, "R10 clear address", errAddr, 32'd0);

    // early end with an outstanding fetch (R11)
    maxLat = 1000;
    @(negedge clk);
    startValid = 1'b1; startAddr = 32'h0000_9000; wordCount = 16'd3; sizeSel = 2'd2;
    @(negedge clk);
    startValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      shiftBit(b);
      check(b == 1'b0, "R2 zero status while fetch pending", {31'd0, b}, 32'd0);
    end
    @(negedge clk);
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge clk);
    updateDr = 1'b0;
    #1 check(busReq == 1'b0, "R11 request dropped on update", {31'd0, busReq}, 32'd0);
    strayAck = 1'b1;
    @(negedge clk);
    strayAck = 1'b0;
    for (int k = 0; k < 5; k++) begin
      shiftBit(b);
      check(b == 1'b0 && busReq == 1'b0, "R11 quiet after abort", {31'd0, b}, 32'd0);
    end
    @(negedge clk); shiftDr = 1'b0;
    runBurst(2'd2, 2, 32'h0000_A000, 0, 1, 0);

    // zero word count ignored (R12)
    @(negedge clk);
    startValid = 1'b1; startAddr = 32'h0000_B000; wordCount = 16'd0; sizeSel = 2'd2;
    @(negedge clk);
    startValid = 1'b0;
    #1 check(busReq == 1'b0, "R12 zero count issues no fetch", {31'd0, busReq}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      shiftBit(b);
      check(b == 1'b0, "R12 zero count sends nothing", {31'd0, b}, 32'd0);
    end
    @(negedge clk); shiftDr = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule